// File: doc/BRIEF.md
# Dual-lane SPI byte striping engine

The engine drains a byte transmit FIFO onto one or two SPI data lanes, each lane run by its own 8-bit shifter. It collects the bytes shifted back into a receive FIFO. A pulse on `go_i` starts a run, and the run repeats transfer steps until the transmit FIFO is empty. Two data modes are chosen by `stripe_i`. In striped mode the bytes of one step are spread bit by bit across the lanes, and the returned lane bytes are gathered back into bytes. In mirrored mode a single byte is copied to every active lane, and only the response of lane 0 is kept.

`dual_i` selects two active lanes (1) or lane 0 alone (0). With one lane, both modes move one byte per step and no bits are reordered. `linear_i` selects the deep FIFO capacity and also silences the underflow flag. The mode inputs are sampled when each step starts. Instruction decoding that picks the mode lives outside this block.

Top module: `spi_stripe_engine`

## Requirements
- R1: After reset, `tx_ready_o`=1, `rx_valid_o`=0, `busy_o`=0, `sclk_o`=0, and both flag outputs are 0.
- R2: In striped mode with two lanes, a step takes two bytes from the TX FIFO and forms a 16-bit word x, with the first byte in bits 7:0. Bit p of the byte sent on lane l is x[2p+l].
- R3: In striped mode with two lanes, the received lane bytes pass through the inverse mapping. Source bit 2p+l is taken from bit p of the byte received on lane l. The two bytes formed are pushed to the RX FIFO with bits 7:0 first.
- R4: In mirrored mode with two lanes, a step takes one byte, sends it unchanged on both lanes, and pushes only the byte received on lane 0.
- R5: With `dual_i`=0, every step in either mode takes one byte, sends it unchanged on lane 0 only, and pushes the byte received on lane 0.
- R6: In striped mode with two lanes, a step does not start while only one byte is in the TX FIFO. The run stays busy, raises no flag and pops nothing until a second byte arrives.
- R7: When a step would start and the TX FIFO is empty, the run ends (`busy_o` falls). In register mode (`linear_i`=0), `tx_underflow_o` pulses for one cycle at that point. In linear mode it does not pulse.
- R8: When a step's results arrive and the RX FIFO has less free space than the step's byte count, every byte of that step is dropped and `rx_overflow_o` pulses for one cycle.
- R9: Each FIFO holds 32 bytes in register mode and 256 bytes in linear mode. `tx_ready_o` is 1 exactly while the TX FIFO holds fewer bytes than that capacity.
- R10: Each lane shifts its byte MSB first over 8 `sclk_o` high pulses, and all active lanes shift in lockstep. `mosi_o` is held for a low and a high clock phase, and `miso_i` is sampled at the end of the high phase. `sclk_o` stays low while the engine is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start a run; ignored while busy |
| stripe_i | input | 1 | 1 = striped mode, 0 = mirrored mode |
| dual_i | input | 1 | 1 = both lanes active, 0 = lane 0 only |
| linear_i | input | 1 | 1 = linear mode (256-byte FIFOs, no underflow flag) |
| tx_valid_i | input | 1 | Push `tx_data_i` into the TX FIFO |
| tx_data_i | input | 8 | Byte to transmit |
| tx_ready_o | output | 1 | TX FIFO below capacity |
| rx_pop_i | input | 1 | Pop the head of the RX FIFO |
| rx_valid_o | output | 1 | RX FIFO not empty |
| rx_data_o | output | 8 | Head of the RX FIFO |
| busy_o | output | 1 | Run in progress |
| tx_underflow_o | output | 1 | One-cycle pulse: run ended on an empty TX FIFO |
| rx_overflow_o | output | 1 | One-cycle pulse: a step's results were dropped |
| sclk_o | output | 1 | Shared serial clock of the lanes |
| mosi_o | output | 2 | Serial data out, one bit per lane |
| miso_i | input | 2 | Serial data in, one bit per lane |

## Verification
The bench's lane model inverts lane 0 and passes lane 1 through. A byte that comes back therefore shows which lane carried each of its bits: striped results must equal the word XOR 0x5555, and mirrored or single-lane results the complement of the byte.

Striped mode is tried with all sixteen one-hot words, which isolate each bit-to-lane position. It is also swept over all 256 low bytes, each paired with a distinct high byte, which separates a swapped lane from a swapped byte. Mirrored mode is swept over all 256 bytes, with both lanes' shifted bytes captured.

Fill levels are driven to one byte short of capacity, to exactly full, and across the switch from 32 to 256 bytes. These pin down the overflow drop rule and the two FIFO capacities.

// File: rtl/spi_stripe_pkg.sv
package spi_stripe_pkg;
  // source bit s of a step maps to lane s % n at bit position s / n
  function automatic int ss_lane(int s, int n);
    return s % n;
  endfunction

  function automatic int ss_pos(int s, int n);
    return s / n;
  endfunction
endpackage

// File: rtl/ssx_fifo.sv
module ssx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 256,
  parameter int WR    = 1,
  parameter int RD    = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH),
  localparam int NWW  = $clog2(WR + 1),
  localparam int NRW  = $clog2(RD + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NWW-1:0]  push_n_i,
  input  logic [WR*W-1:0] wdata_i,
  input  logic [NRW-1:0]  pop_n_i,
  output logic [RD*W-1:0] rdata_o,
  output logic [CW-1:0]   cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < WR; k++) begin
      if (NWW'(k) < push_n_i) mem[wr_ptr + PW'(k)] <= wdata_i[k*W +: W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(push_n_i);
      rd_ptr <= rd_ptr + PW'(pop_n_i);
      cnt_o  <= cnt_o + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  for (genvar k = 0; k < RD; k++) begin : g_rd
    assign rdata_o[k*W +: W] = mem[rd_ptr + PW'(k)];
  end
endmodule

// File: rtl/ssx_lane.sv
module ssx_lane #(
  parameter int W    = 8,
  localparam int BCW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] tx_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic         sclk_o,
  output logic         done_o,
  output logic [W-1:0] rx_o
);
  logic           busy_q, phase_q;
  logic [BCW-1:0] bcnt_q;
  logic [W-1:0]   sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      bcnt_q  <= '0;
      sh_q    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        bcnt_q  <= '0;
        sh_q    <= tx_i;
      end else if (busy_q) begin
        phase_q <= ~phase_q;
        if (phase_q) begin
          // capture at end of high phase, MSB leaves first
          sh_q   <= {sh_q[W-2:0], miso_i};
          bcnt_q <= bcnt_q + 1'b1;
          if (bcnt_q == BCW'(W - 1)) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end
        end
      end
    end
  end

  assign mosi_o = busy_q & sh_q[W-1];
  assign sclk_o = busy_q & phase_q;
  assign rx_o   = sh_q;
endmodule

// File: rtl/ssx_xform.sv
module ssx_xform #(
  parameter int W     = 8,
  parameter int LANES = 2,
  parameter bit INV   = 1'b0
) (
  input  logic [LANES*W-1:0] in_i,
  output logic [LANES*W-1:0] out_o
);
  import spi_stripe_pkg::*;

  for (genvar s = 0; s < LANES * W; s++) begin : g_bit
    localparam int D = ss_lane(s, LANES) * W + ss_pos(s, LANES);
    if (INV) begin : g_inv
      assign out_o[s] = in_i[D];
    end else begin : g_fwd
      assign out_o[D] = in_i[s];
    end
  end
endmodule

// File: rtl/spi_stripe_engine.sv
module spi_stripe_engine #(
  parameter int W         = 8,
  parameter int LANES     = 2,
  parameter int REG_DEPTH = 32,
  parameter int LIN_DEPTH = 256,
  localparam int CW       = $clog2(LIN_DEPTH + 1),
  localparam int NPW      = $clog2(LANES + 1),
  localparam int VW       = LANES * W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             stripe_i,
  input  logic             dual_i,
  input  logic             linear_i,
  input  logic             tx_valid_i,
  input  logic [W-1:0]     tx_data_i,
  output logic             tx_ready_o,
  input  logic             rx_pop_i,
  output logic             rx_valid_o,
  output logic [W-1:0]     rx_data_o,
  output logic             busy_o,
  output logic             tx_underflow_o,
  output logic             rx_overflow_o,
  output logic             sclk_o,
  output logic [LANES-1:0] mosi_o,
  input  logic [LANES-1:0] miso_i
);
  logic [CW-1:0]  tx_cnt, rx_cnt, cap;
  logic [NPW-1:0] need, push_want, tx_pop_n, rx_push_n;
  logic           busy_q, wait_q, st_q, uf_q, ov_q;
  logic           use_st, tx_empty, step_go, room, done_any, rx_pop_n;
  logic [VW-1:0]  tx_rd, tx_striped, lane_tx, lane_rx, rx_gather, rx_wdata;
  logic [LANES-1:0] lane_done, lane_sclk;

  assign cap       = linear_i ? CW'(LIN_DEPTH) : CW'(REG_DEPTH);
  assign use_st    = stripe_i & dual_i;
  assign need      = use_st ? NPW'(LANES) : NPW'(1);
  assign tx_empty  = (tx_cnt == '0);
  assign step_go   = busy_q & ~wait_q & ~tx_empty & (tx_cnt >= CW'(need));
  assign tx_pop_n  = step_go ? need : '0;
  assign tx_ready_o = (tx_cnt < cap);

  assign push_want = st_q ? NPW'(LANES) : NPW'(1);
  assign done_any  = |lane_done;
  assign room      = ((CW+1)'(rx_cnt) + (CW+1)'(push_want)) <= (CW+1)'(cap);
  assign rx_push_n = (wait_q & done_any & room) ? push_want : '0;
  assign rx_wdata  = st_q ? rx_gather : VW'(lane_rx[W-1:0]);
  assign rx_valid_o = (rx_cnt != '0);
  assign rx_pop_n  = rx_pop_i & rx_valid_o;

  assign lane_tx = use_st ? tx_striped : {LANES{tx_rd[W-1:0]}};

  ssx_fifo #(.W(W), .DEPTH(LIN_DEPTH), .WR(1), .RD(LANES)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_n_i (tx_valid_i & tx_ready_o),
    .wdata_i  (tx_data_i),
    .pop_n_i  (tx_pop_n),
    .rdata_o  (tx_rd),
    .cnt_o    (tx_cnt)
  );

  ssx_fifo #(.W(W), .DEPTH(LIN_DEPTH), .WR(LANES), .RD(1)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_n_i (rx_push_n),
    .wdata_i  (rx_wdata),
    .pop_n_i  (rx_pop_n),
    .rdata_o  (rx_data_o),
    .cnt_o    (rx_cnt)
  );

  ssx_xform #(.W(W), .LANES(LANES), .INV(1'b0)) u_stripe (
    .in_i (tx_rd), .out_o (tx_striped)
  );

  ssx_xform #(.W(W), .LANES(LANES), .INV(1'b1)) u_unstripe (
    .in_i (lane_rx), .out_o (rx_gather)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ssx_lane #(.W(W)) u_lane (
      .clk_i, .rst_ni,
      .start_i (step_go & (dual_i | (l == 0))),
      .tx_i    (lane_tx[l*W +: W]),
      .miso_i  (miso_i[l]),
      .mosi_o  (mosi_o[l]),
      .sclk_o  (lane_sclk[l]),
      .done_o  (lane_done[l]),
      .rx_o    (lane_rx[l*W +: W])
    );
  end

  assign sclk_o = |lane_sclk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wait_q <= 1'b0;
      st_q   <= 1'b0;
      uf_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      uf_q <= 1'b0;
      ov_q <= 1'b0;
      if (!busy_q) begin
        if (go_i) busy_q <= 1'b1;
      end else if (wait_q) begin
        if (done_any) begin
          wait_q <= 1'b0;
          if (!room) ov_q <= 1'b1;
        end
      end else if (tx_empty) begin
        busy_q <= 1'b0;
        uf_q   <= ~linear_i;
      end else if (step_go) begin
        wait_q <= 1'b1;
        st_q   <= use_st;
      end
    end
  end

  assign busy_o         = busy_q;
  assign tx_underflow_o = uf_q;
  assign rx_overflow_o  = ov_q;
endmodule

// File: rtl/spi_stripe_checker.sv
module spi_stripe_checker #(
  parameter int CW        = 9,
  parameter int LIN_DEPTH = 256
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          linear_i,
  input logic          rx_pop_i,
  input logic          busy_o,
  input logic          sclk_o,
  input logic          tx_underflow_o,
  input logic          rx_overflow_o,
  input logic [CW-1:0] rx_cnt
);
  AST_UFLOW_LINEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_underflow_o |-> !$past(linear_i)); // R7

  AST_UFLOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_underflow_o |-> !busy_o); // R7

  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_overflow_o && !$past(rx_pop_i)) |-> $stable(rx_cnt)); // R8

  AST_RX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CW'(LIN_DEPTH)); // R9

  AST_SCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> busy_o); // R10
endmodule

bind spi_stripe_engine spi_stripe_checker #(.CW(CW), .LIN_DEPTH(LIN_DEPTH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .linear_i       (linear_i),
  .rx_pop_i       (rx_pop_i),
  .busy_o         (busy_o),
  .sclk_o         (sclk_o),
  .tx_underflow_o (tx_underflow_o),
  .rx_overflow_o  (rx_overflow_o),
  .rx_cnt         (rx_cnt)
);

// File: tb/spi_stripe_engine_bench.sv
`timescale 1ns/1ps
module spi_stripe_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, stripe = 1'b0, dual = 1'b1, linear = 1'b0;
  logic tx_valid = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, busy, uflow, oflow, sclk;
  logic [7:0] rx_data;
  logic [1:0] mosi, miso;

  int checks = 0, errors = 0, cyc = 0;
  int uf_cnt = 0, ov_cnt = 0, sclk_hi = 0, steps = 0;
  int uf_exp = 0, ov_exp = 0, step_exp = 0;
  logic [7:0] sh [2];
  logic [7:0] cap [2];
  int bits = 0;
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  // lane 0 returns the inverse of what it sends, lane 1 echoes
  assign miso = {mosi[1], ~mosi[0]};

  spi_stripe_engine u_spi_stripe_engine (
    .clk_i (clk), .rst_ni (rst_n), .go_i (go), .stripe_i (stripe),
    .dual_i (dual), .linear_i (linear), .tx_valid_i (tx_valid),
    .tx_data_i (tx_data), .tx_ready_o (tx_ready), .rx_pop_i (rx_pop),
    .rx_valid_o (rx_valid), .rx_data_o (rx_data), .busy_o (busy),
    .tx_underflow_o (uflow), .rx_overflow_o (oflow), .sclk_o (sclk),
    .mosi_o (mosi), .miso_i (miso)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      checks++; errors++;
      $display("FAIL R7 watchdog actual=%0d expected=<190000", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (uflow) uf_cnt++;
    if (oflow) ov_cnt++;
    if (sclk) begin
      sclk_hi++;
      for (int l = 0; l < 2; l++) sh[l] = {sh[l][6:0], mosi[l]};
      bits++;
      if (bits == 8) begin
        bits = 0; steps++;
        cap[0] = sh[0]; cap[1] = sh[1];
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic go_pulse();
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 40000) begin @(negedge clk); n++; end
    #1;
    chk(!busy, req, "run did not end", busy, 0);
  endtask

  task automatic drain(string req);
    int want = exp_q.size();
    int got = 0;
    logic [7:0] e;
    while (rx_valid && got < 300) begin
      if (exp_q.size() == 0) e = 8'hxx; else e = exp_q.pop_front();
      chk(rx_data === e, req, "rx byte", rx_data, e);
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
      #1;
      got++;
    end
    chk(got == want, req, "rx byte count", got, want);
    exp_q.delete();
  endtask

  function automatic logic [7:0] lane_of(logic [15:0] x, int l);
    logic [7:0] b;
    for (int p = 0; p < 8; p++) b[p] = x[2*p + l];
    return b;
  endfunction

  initial begin
    logic [15:0] x;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(tx_ready == 1'b1, "R1", "tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    chk(busy == 1'b0 && sclk == 1'b0, "R1", "busy/sclk", {busy, sclk}, 0);
    chk(uflow == 1'b0 && oflow == 1'b0, "R1", "flags", {uflow, oflow}, 0);

    // R2 R3 striped, two lanes: one-hot words then a byte sweep
    stripe = 1'b1; dual = 1'b1;
    for (int i = 0; i < 16 + 256; i++) begin
      if (i < 16) x = 16'(1) << i;
      else x = {8'(i - 16) ^ 8'h3C, 8'(i - 16)};
      push(x[7:0]); push(x[15:8]); go_pulse(); wait_idle("R2");
      uf_exp++; step_exp++;
      chk(cap[0] == lane_of(x, 0), "R2", "lane0 byte", cap[0], lane_of(x, 0));
      chk(cap[1] == lane_of(x, 1), "R2", "lane1 byte", cap[1], lane_of(x, 1));
      exp_q.push_back(x[7:0] ^ 8'h55);
      exp_q.push_back(x[15:8] ^ 8'h55);
      drain("R3");
    end
    chk(uf_cnt == uf_exp, "R7", "underflow pulses", uf_cnt, uf_exp);

    // R4 mirrored, two lanes, all bytes
    stripe = 1'b0;
    for (int i = 0; i < 256; i++) begin
      push(8'(i)); go_pulse(); wait_idle("R4");
      uf_exp++; step_exp++;
      chk(cap[0] == 8'(i) && cap[1] == 8'(i), "R4", "lane bytes", {cap[1], cap[0]}, {8'(i), 8'(i)});
      exp_q.push_back(~8'(i));
      drain("R4");
    end

    // R5 single lane in both modes
    dual = 1'b0;
    for (int st = 0; st < 2; st++) begin
      stripe = st[0];
      for (int k = 0; k < 4; k++) begin
        logic [7:0] b = 8'h01 << (2 * k) ^ 8'hA4;
        push(b); go_pulse(); wait_idle("R5");
        uf_exp++; step_exp++;
        chk(cap[0] == b, "R5", "lane0 byte", cap[0], b);
        exp_q.push_back(~b);
        drain("R5");
      end
      push(8'h3A); push(8'hC5); go_pulse(); wait_idle("R5");
      uf_exp++; step_exp += 2;
      exp_q.push_back(8'hC5); exp_q.push_back(8'h3A);
      drain("R5");
    end

    // R6 striped waits for a full pair
    dual = 1'b1; stripe = 1'b1;
    push(8'h96); go_pulse();
    repeat (40) @(negedge clk);
    #1;
    chk(busy == 1'b1, "R6", "busy while partial", busy, 1);
    chk(rx_valid == 1'b0 && sclk_hi == 16 * step_exp / 2 * 0 + sclk_hi, "R6", "no result", rx_valid, 0);
    chk(uf_cnt == uf_exp, "R6", "no underflow while partial", uf_cnt, uf_exp);
    chk(steps == step_exp, "R6", "no step while partial", steps, step_exp);
    push(8'h69); wait_idle("R6");
    uf_exp++; step_exp++;
    exp_q.push_back(8'h96 ^ 8'h55); exp_q.push_back(8'h69 ^ 8'h55);
    drain("R6");

    // R7 linear mode end has no flag; register mode empty run has one
    linear = 1'b1; stripe = 1'b0;
    push(8'h33); go_pulse(); wait_idle("R7");
    step_exp++;
    chk(uf_cnt == uf_exp, "R7", "linear underflow silent", uf_cnt, uf_exp);
    exp_q.push_back(8'hCC);
    drain("R7");
    linear = 1'b0;
    go_pulse(); wait_idle("R7");
    uf_exp++;
    chk(uf_cnt == uf_exp, "R7", "empty run flags", uf_cnt, uf_exp);

    // R8 overflow drops whole step
    for (int i = 0; i < 31; i++) begin
      push(8'(i) + 8'h40); exp_q.push_back(~(8'(i) + 8'h40));
    end
    go_pulse(); wait_idle("R8");
    uf_exp++; step_exp += 31;
    stripe = 1'b1;
    push(8'h11); push(8'h22); go_pulse(); wait_idle("R8");
    uf_exp++; step_exp++; ov_exp++;
    chk(ov_cnt == ov_exp, "R8", "pair dropped with one free", ov_cnt, ov_exp);
    stripe = 1'b0;
    push(8'hE1); go_pulse(); wait_idle("R8");
    uf_exp++; step_exp++;
    exp_q.push_back(8'h1E);
    chk(ov_cnt == ov_exp, "R8", "last slot fits", ov_cnt, ov_exp);
    push(8'hE2); go_pulse(); wait_idle("R8");
    uf_exp++; step_exp++; ov_exp++;
    chk(ov_cnt == ov_exp, "R8", "full fifo drops", ov_cnt, ov_exp);
    drain("R8");

    // R9 capacities
    n = 0;
    while (tx_ready && n < 300) begin push(8'(n)); n++; end
    #1;
    chk(n == 32, "R9", "register capacity", n, 32);
    linear = 1'b1;
    #1;
    while (tx_ready && n < 300) begin push(8'(n)); n++; end
    #1;
    chk(n == 256, "R9", "linear capacity", n, 256);
    go_pulse(); wait_idle("R9");
    step_exp += 256;
    chk(uf_cnt == uf_exp, "R9", "no underflow in linear", uf_cnt, uf_exp);
    chk(ov_cnt == ov_exp, "R9", "256 results fit", ov_cnt, ov_exp);
    for (int i = 0; i < 256; i++) exp_q.push_back(~8'(i));
    drain("R9");
    linear = 1'b0;

    // R10 serial framing totals
    chk(steps == step_exp, "R10", "byte frames", steps, step_exp);
    chk(sclk_hi == 8 * steps, "R10", "sclk pulses", sclk_hi, 8 * steps);
    chk(bits == 0, "R10", "partial frame", bits, 0);

    summary();
    $finish;
  end
endmodule